// File: doc/BRIEF.md
# Flash Device Identification Probe

This block identifies a parallel flash device attached behind a command sequencer and a byte read port. On a start pulse it asks the sequencer for the read-ID command, reads the vendor byte and the device byte, and, when the device byte is the escape code 0x7E, reads two further device code bytes. The assembled 32-bit identity is compared against a small table of known identities that software loads beforehand, each with a flag telling whether that device leaves ID mode on a single-write reset.

On a hit the block reports the table index and tells the sequencer to issue the reset command with the matched entry's flag. On a miss it resets the device and probes once more with the narrow command-address mask; a second miss ends with the found flag low and an all-zero identity.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, busy, done, found, cmd_req and rd_req are low and id_word is zero.
- R2: A start pulse while idle first requests command op 0x90 (read-ID) with cmd_mask equal to the wide mask 0x7FFF.
- R3: After the read-ID command, reads are made at address 0 then address 1; id_word bits 7:0 take the byte from address 0, bits 15:8 the byte from address 1, and bits 31:16 are zero.
- R4: When the byte from address 1 equals 0x7E, two more reads are made at addresses 0x0E then 0x0F, whose bytes fill id_word bits 23:16 and 31:24.
- R5: Table entries are scanned from index 0 upward; the first entry holding zero ends the table, entries after it never match, and among equal entries the lowest index wins.
- R6: On a hit, the block requests op 0xF0 (reset) with cmd_sngl equal to the matched entry's flag, then finishes with found high and match_idx equal to the entry index.
- R7: On a miss during the wide-mask pass, the block requests reset with cmd_sngl low and then requests read-ID again with cmd_mask 0x07FF.
- R8: On a miss during the narrow-mask pass, the block requests reset with cmd_sngl low and finishes with found low and id_word zero, after exactly two read-ID requests.
- R9: Table writes made while busy is high are ignored.
- R10: Requests are held until their acknowledge; done is high for exactly one cycle, after which busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (taken while idle) |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 3 | Table entry index |
| tbl_id | input | 32 | Identity to store (zero marks table end) |
| tbl_sngl | input | 1 | Single-write reset flag for the entry |
| cmd_req | output | 1 | Command request to the sequencer |
| cmd_op | output | 8 | Command opcode |
| cmd_mask | output | 17 | Command-address mask to use |
| cmd_sngl | output | 1 | Reset may be done with a single write |
| cmd_done | input | 1 | Sequencer acknowledge, one cycle |
| rd_req | output | 1 | Read request |
| rd_addr | output | 17 | Read address |
| rd_done | input | 1 | Read acknowledge, one cycle, data valid |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished, one cycle |
| found | output | 1 | Last probe matched a table entry |
| id_word | output | 32 | Identity read (zero after a failed probe) |
| match_idx | output | 3 | Index of the matched entry |

## Verification
The hardest path to reach is the narrow-mask retry that succeeds: the device must answer garbage while the wide mask is used and its real identity once the narrow mask appears. The bench's device model watches the mask carried by each read-ID command and only answers truthfully when the wide mask is allowed or the narrow one is in force, and it sweeps the match position, the table terminator position, the escape code and the mask behaviour so both retry outcomes and both ID lengths occur against every table shape.

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int AW = 17,
  parameter int ENTRIES = 8,
  parameter int IW = $clog2(ENTRIES),
  parameter logic [AW-1:0] MASK_WIDE = 'h7FFF,
  parameter logic [AW-1:0] MASK_NARROW = 'h07FF,
  parameter logic [7:0] OP_ID = 8'h90,
  parameter logic [7:0] OP_RST = 8'hF0,
  parameter logic [7:0] ESC = 8'h7E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  logic [31:0]   tbl_id,
  input  logic          tbl_sngl,
  output logic          cmd_req,
  output logic [7:0]    cmd_op,
  output logic [AW-1:0] cmd_mask,
  output logic          cmd_sngl,
  input  logic          cmd_done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_done,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [31:0]   id_word,
  output logic [IW-1:0] match_idx
);
  typedef enum logic [2:0] {S_IDLE, S_CID, S_RD, S_CMP, S_CRST, S_FIN} st_t;

  st_t st;
  logic [31:0] tbl_q [ENTRIES];
  logic [ENTRIES-1:0] flg_q;
  logic narrow, hit_q, found_q, hit, live;
  logic [1:0] bsel;
  logic [31:0] idw;
  logic [IW-1:0] idx_q, hidx;

  always_comb begin
    hit = 1'b0;
    hidx = '0;
    live = 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin
      live = live && (tbl_q[i] != 32'h0);
      if (live && !hit && tbl_q[i] == idw) begin
        hit = 1'b1;
        hidx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
      flg_q <= '0;
    end else if (tbl_we && st == S_IDLE) begin
      tbl_q[tbl_idx] <= tbl_id;
      flg_q[tbl_idx] <= tbl_sngl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      narrow <= 1'b0;
      bsel <= '0;
      idw <= '0;
      hit_q <= 1'b0;
      idx_q <= '0;
      found_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          narrow <= 1'b0;
          idw <= '0;
          hit_q <= 1'b0;
          idx_q <= '0;
          found_q <= 1'b0;
          st <= S_CID;
        end
        S_CID: if (cmd_done) begin
          bsel <= '0;
          st <= S_RD;
        end
        S_RD: if (rd_done) begin
          idw[8*bsel +: 8] <= rd_data;
          if (bsel == 2'd3 || (bsel == 2'd1 && rd_data != ESC)) st <= S_CMP;
          else bsel <= bsel + 2'd1;
        end
        S_CMP: begin
          hit_q <= hit;
          idx_q <= hidx;
          st <= S_CRST;
        end
        S_CRST: if (cmd_done) begin
          if (hit_q) begin
            found_q <= 1'b1;
            st <= S_FIN;
          end else if (!narrow) begin
            narrow <= 1'b1;
            idw <= '0;
            st <= S_CID;
          end else begin
            idw <= '0;
            st <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_req   = (st == S_CID) || (st == S_CRST);
  assign cmd_op    = (st == S_CRST) ? OP_RST : OP_ID;
  assign cmd_mask  = narrow ? MASK_NARROW : MASK_WIDE;
  assign cmd_sngl  = (st == S_CRST) && hit_q && flg_q[idx_q];
  assign rd_req    = (st == S_RD);
  assign rd_addr   = {{(AW-4){1'b0}}, {3{bsel[1]}}, bsel[0]};
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign found     = found_q;
  assign id_word   = idw;
  assign match_idx = idx_q;

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_op)));
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |=> (rd_req && $stable(rd_addr)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (id_word == 32'h0));
  p_escape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr[3]) |-> (id_word[15:8] == ESC));
endmodule

// File: tb/flash_id_probe_bench.sv
module flash_id_probe_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic tbl_we = 1'b0, tbl_sngl = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [31:0] tbl_id = '0;
  logic cmd_req, cmd_sngl, rd_req, busy, done, found;
  logic [7:0] cmd_op;
  logic [16:0] cmd_mask, rd_addr;
  logic cmd_done = 1'b0, rd_done = 1'b0;
  logic [7:0] rd_data = '0;
  logic [31:0] id_word;
  logic [2:0] match_idx;

  flash_id_probe u_flash_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_id(tbl_id), .tbl_sngl(tbl_sngl), .cmd_req(cmd_req), .cmd_op(cmd_op),
    .cmd_mask(cmd_mask), .cmd_sngl(cmd_sngl), .cmd_done(cmd_done), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data), .busy(busy), .done(done),
    .found(found), .id_word(id_word), .match_idx(match_idx));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] d_man, d_dev, d_b2, d_b3;
  logic wide_ok;
  logic clr = 1'b0;
  int nid, nrst, nrd;
  logic last_sngl;
  logic [16:0] cur_mask;
  logic [16:0] mask_log [4];
  logic [16:0] rd_log [8];
  logic [31:0] mt [8];
  logic mf [8];

  function automatic logic [7:0] dev_byte(input logic [16:0] a, input logic [16:0] m);
    if (m != 17'h007FF && !wide_ok) return 8'hFF;
    case (a)
      17'h0: return d_man;
      17'h1: return d_dev;
      17'hE: return d_b2;
      17'hF: return d_b3;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    cmd_done <= cmd_req && !cmd_done;
    rd_done <= rd_req && !rd_done;
    if (clr) begin
      nid <= 0; nrst <= 0; nrd <= 0; last_sngl <= 1'b0;
    end else begin
      if (cmd_req && !cmd_done) begin
        if (cmd_op == 8'h90) begin
          if (nid < 4) mask_log[nid] <= cmd_mask;
          nid <= nid + 1;
          cur_mask <= cmd_mask;
        end else if (cmd_op == 8'hF0) begin
          nrst <= nrst + 1;
          last_sngl <= cmd_sngl;
        end
      end
      if (rd_req && !rd_done) begin
        rd_data <= dev_byte(rd_addr, cur_mask);
        if (nrd < 8) rd_log[nrd] <= rd_addr;
        nrd <= nrd + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    finish_run();
  end

  function automatic int lookup(input logic [31:0] id);
    for (int i = 0; i < 8; i++) begin
      if (mt[i] == 32'h0) return -1;
      if (mt[i] == id) return i;
    end
    return -1;
  endfunction

  task automatic load_table();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 3'(i); tbl_id = mt[i]; tbl_sngl = mf[i];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic probe(input logic poke);
    int w;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      tbl_we = 1'b1; tbl_idx = 3'd0; tbl_id = {16'h0, d_dev, d_man}; tbl_sngl = 1'b1;
      @(negedge clk); tbl_we = 1'b0;
    end
    w = 0;
    while (!done && w < 300) begin @(negedge clk); w++; end
    chk(done, "R10 done seen", {31'h0, done}, 32'h1);
  endtask

  task automatic scenario(input logic poke);
    logic [31:0] real_id, wide_id;
    int hw, hn, exp_idx, exp_nid, k;
    logic [16:0] exp_rd [8];
    logic exp_found;
    real_id = (d_dev == 8'h7E) ? {d_b3, d_b2, d_dev, d_man} : {16'h0, d_dev, d_man};
    wide_id = wide_ok ? real_id : 32'h0000FFFF;
    hw = lookup(wide_id);
    hn = lookup(real_id);
    k = 0;
    exp_rd[k++] = 17'h0; exp_rd[k++] = 17'h1;
    if (wide_id[15:8] == 8'h7E) begin exp_rd[k++] = 17'hE; exp_rd[k++] = 17'hF; end
    if (hw >= 0) begin exp_found = 1'b1; exp_idx = hw; exp_nid = 1; end
    else begin
      exp_nid = 2;
      exp_rd[k++] = 17'h0; exp_rd[k++] = 17'h1;
      if (d_dev == 8'h7E) begin exp_rd[k++] = 17'hE; exp_rd[k++] = 17'hF; end
      exp_found = (hn >= 0); exp_idx = (hn >= 0) ? hn : 0;
    end
    if (poke) begin exp_found = 1'b0; exp_nid = 2; end
    probe(poke);
    chk(found == exp_found, "R5/R6/R8 found", {31'h0, found}, {31'h0, exp_found});
    if (exp_found) begin
      chk(id_word == (exp_nid == 1 ? wide_id : real_id), "R3/R4 id_word", id_word,
          exp_nid == 1 ? wide_id : real_id);
      chk(match_idx == 3'(exp_idx), "R5 match_idx", {29'h0, match_idx}, exp_idx);
      chk(last_sngl == mf[exp_idx], "R6 reset flag", {31'h0, last_sngl}, {31'h0, mf[exp_idx]});
    end else begin
      chk(id_word == 32'h0, "R8 zero id", id_word, 32'h0);
      chk(last_sngl == 1'b0, "R7/R8 reset flag low", {31'h0, last_sngl}, 32'h0);
    end
    chk(nid == exp_nid, "R7/R8 read-ID count", nid, exp_nid);
    chk(nrst == exp_nid, "R6/R7 reset count", nrst, exp_nid);
    chk(mask_log[0] == 17'h07FFF, "R2 first mask", {15'h0, mask_log[0]}, 32'h7FFF);
    if (exp_nid == 2)
      chk(mask_log[1] == 17'h007FF, "R7 narrow mask", {15'h0, mask_log[1]}, 32'h07FF);
    if (!poke) begin
      chk(nrd == k, "R3/R4 read count", nrd, k);
      for (int i = 0; i < k && i < 8; i++)
        chk(rd_log[i] == exp_rd[i], "R3/R4 read address", {15'h0, rd_log[i]}, {15'h0, exp_rd[i]});
    end
    @(negedge clk);
    chk(!done && !busy, "R10 done single cycle", {30'h0, done, busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !found && !cmd_req && !rd_req && id_word == 32'h0, "R1 reset state",
        {27'h0, busy, done, found, cmd_req, rd_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && id_word == 32'h0, "R1 after release", id_word, 32'h0);

    for (int esc = 0; esc < 2; esc++)
      for (int wk = 0; wk < 2; wk++)
        for (int pos = 0; pos < 8; pos++)
          for (int term = 0; term < 9; term++) begin
            d_man = 8'h10 + 8'(pos);
            d_dev = esc ? 8'h7E : 8'h40 + 8'(pos);
            d_b2 = 8'h5A; d_b3 = 8'hC3 + 8'(pos);
            wide_ok = wk[0];
            for (int i = 0; i < 8; i++) begin
              mt[i] = 32'hA500_0000 + i;
              mf[i] = i[0] ^ esc[0];
            end
            if (term < 8) mt[term] = 32'h0;
            if (pos != term)
              mt[pos] = esc ? {d_b3, d_b2, d_dev, d_man} : {16'h0, d_dev, d_man};
            load_table();
            scenario(1'b0);
          end

    // R5 duplicates: lowest index wins
    d_man = 8'h01; d_dev = 8'h6B; wide_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin mt[i] = 32'hB000_0000 + i; mf[i] = 1'b0; end
    mt[2] = 32'h0000_6B01; mt[5] = 32'h0000_6B01; mf[2] = 1'b1;
    load_table();
    scenario(1'b0);
    chk(match_idx == 3'd2, "R5 lowest duplicate", {29'h0, match_idx}, 32'd2);

    // R9 writes during busy ignored: table empty of this id, poke during probe
    d_man = 8'h37; d_dev = 8'h22;
    for (int i = 0; i < 8; i++) begin mt[i] = 32'hC000_0000 + i; mf[i] = 1'b0; end
    load_table();
    scenario(1'b1);
    scenario(1'b0);
    chk(!found, "R9 write while busy ignored", {31'h0, found}, 32'h0);

    finish_run();
  end
endmodule